// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter with Split Count Enables

This block is a synchronous binary up-counter whose register width is a parameter (four bits by default). On every rising clock edge it performs exactly one of four operations, picked by a fixed priority: clear to zero, parallel load of an input word, increment by one, or hold. All state changes happen on the clock edge. The counter has no asynchronous reset. After power-up its value is undefined until the first clear or load.

Counting needs two enables, and the two have different roles. `cnt_en` takes part only in deciding whether the counter increments. `carry_en` also gates the carry output. `carry_out` is combinational from the count and `carry_en`. A downstream stage therefore sees it in the same cycle. Several stages can be chained into a wider counter by feeding one stage's `carry_out` into the next stage's `carry_en`, with a common `cnt_en` driving every stage. The enable structure that derives the per-bit toggle terms is a parameter: a serial AND chain or a parallel set of wide ANDs.

Top module: `presc_counter`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `count` becomes all zeros after that edge, whatever the values of `load_n`, `cnt_en`, `carry_en` and `din`.
- R2: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `din` after that edge, whatever the values of the two enables.
- R3: When `clear_n` and `load_n` are both 1 and `cnt_en` and `carry_en` are both 1 at a rising edge, `count` becomes the previous count plus one, modulo 2^WIDTH.
- R4: When `clear_n` and `load_n` are both 1 and either `cnt_en` or `carry_en` is 0 at a rising edge, `count` keeps its value.
- R5: `carry_out` is 1 exactly when `count` is all ones and `carry_en` is 1. It follows changes of these inputs in the same cycle, without waiting for a clock edge.
- R6: While `carry_en` is 0, `carry_out` is 0 even when `count` is all ones, and `cnt_en` has no effect on `carry_out`.
- R7: While counting freely, the counter wraps from all ones to all zeros, and `carry_out` drops after that edge. Bit i of `count` then toggles with a period of 2^(i+1) clocks.
- R8: Two stages chained as described above count as one counter of twice the width. The upper stage increments only in the cycle in which the lower stage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable that does not affect the carry |
| carry_en | input | 1 | Count enable that also gates `carry_out` |
| din | input | WIDTH | Value taken on a load |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count carry, gated by `carry_en` |

## Verification
The bench builds the main instance with WIDTH=4 and the parallel enable structure. At this width the wrap from 15 to 0, the terminal-count carry and a full free-running period of every bit all fall within a few dozen cycles. It also builds two further 4-bit instances with the serial enable structure, chained into an 8-bit counter. This exercises the other generate branch and the cascade through `carry_en` over a full 256-state cycle. Randomised sequences of clear, load and enable combinations check the priority order against the behavioural model on every clock.

// File: rtl/presc_pkg.sv
package presc_pkg;

   // Structure used to derive the per-bit toggle enables.
   typedef enum logic {
      CHAIN_SERIAL   = 1'b0,
      CHAIN_PARALLEL = 1'b1
   } chain_e;

   // Operation applied at the next rising edge.
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } op_e;

   localparam int unsigned MAX_WIDTH = 64;

endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
   import presc_pkg::*;
(
   input  logic clear_n,
   input  logic load_n,
   input  logic cnt_en,
   input  logic carry_en,
   output op_e  op
);

   // Fixed priority: clear, then load, then count (both enables), else hold.
   always_comb begin
      if (!clear_n)
         op = OP_CLEAR;
      else if (!load_n)
         op = OP_LOAD;
      else if (cnt_en && carry_en)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/presc_toggle_net.sv
module presc_toggle_net
   import presc_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter chain_e      CHAIN = CHAIN_PARALLEL
) (
   input  logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] tgl,
   output logic             all_ones
);

   generate
      if (CHAIN == CHAIN_SERIAL) begin : g_serial
         // Each bit's enable is built from the one below it: long path, small area.
         assign tgl[0] = 1'b1;
         for (genvar i = 1; i < WIDTH; i++) begin : g_link
            assign tgl[i] = tgl[i-1] & q[i-1];
         end
         assign all_ones = tgl[WIDTH-1] & q[WIDTH-1];
      end else begin : g_parallel
         // Each bit's enable is a wide AND of all lower bits: one level of logic.
         assign tgl[0] = 1'b1;
         for (genvar i = 1; i < WIDTH; i++) begin : g_wide
            assign tgl[i] = &q[i-1:0];
         end
         assign all_ones = &q;
      end
   endgenerate

   // R5: the terminal-count flag can only be set while the top bit is allowed to toggle.
   always_comb begin
      a_ones_needs_top_r5: assert (!all_ones || tgl[WIDTH-1]);
   end

endmodule

// File: rtl/presc_cell.sv
module presc_cell
   import presc_pkg::*;
(
   input  logic clk,
   input  op_e  op,
   input  logic d_bit,
   input  logic tgl,
   output logic q_bit
);

   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: q_bit <= 1'b0;
         OP_LOAD:  q_bit <= d_bit;
         OP_COUNT: q_bit <= q_bit ^ tgl;
         default:  q_bit <= q_bit;
      endcase
   end

endmodule

// File: rtl/presc_counter.sv
module presc_counter
   import presc_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter chain_e      CHAIN = CHAIN_PARALLEL
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             load_n,
   input  logic             cnt_en,
   input  logic             carry_en,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] count,
   output logic             carry_out
);

   localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

   generate
      if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("presc_counter: WIDTH out of range");
      end
   endgenerate

   op_e              op;
   logic [WIDTH-1:0] tgl;
   logic             all_ones;

   presc_ctrl u_ctrl (
      .clear_n  (clear_n),
      .load_n   (load_n),
      .cnt_en   (cnt_en),
      .carry_en (carry_en),
      .op       (op)
   );

   presc_toggle_net #(
      .WIDTH (WIDTH),
      .CHAIN (CHAIN)
   ) u_net (
      .q        (count),
      .tgl      (tgl),
      .all_ones (all_ones)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         presc_cell u_cell (
            .clk   (clk),
            .op    (op),
            .d_bit (din[i]),
            .tgl   (tgl[i]),
            .q_bit (count[i])
         );
      end
   endgenerate

   // Combinational carry: only the carry-gating enable takes part.
   assign carry_out = carry_en & all_ones;

   // Assertions next to the logic they guard.
   // Clear is the only reset this block has, so the clear check is not disabled by it.
   p_clear_r1: assert property (@(posedge clk)
      !clear_n |=> count == '0);

   p_load_r2: assert property (@(posedge clk) disable iff (!clear_n)
      !load_n |=> count == $past(din));

   p_count_r3: assert property (@(posedge clk) disable iff (!clear_n)
      (load_n && cnt_en && carry_en) |=> count == WIDTH'($past(count) + 1'b1));

   p_hold_r4: assert property (@(posedge clk) disable iff (!clear_n)
      (load_n && !(cnt_en && carry_en)) |=> $stable(count));

   p_carry_full_r5: assert property (@(posedge clk) disable iff (!clear_n)
      carry_out |-> count == ONES);

   p_carry_gate_r6: assert property (@(posedge clk) disable iff (!clear_n)
      !carry_en |-> !carry_out);

   p_wrap_r7: assert property (@(posedge clk) disable iff (!clear_n)
      (carry_out && cnt_en && load_n) |=> count == '0);

endmodule

// File: tb/test_presc_counter.sv
module test_presc_counter;
   import presc_pkg::*;

   localparam int W      = 4;
   localparam int MAXV   = (1 << W) - 1;
   localparam int CYCLES = 200000;

   logic         clk = 1'b0;
   logic         clear_n, load_n, cnt_en, carry_en;
   logic [W-1:0] din;
   logic [W-1:0] count;
   logic         carry_out;

   // Cascade pair
   logic         c_clear_n, c_en;
   logic [W-1:0] c_lo, c_hi;
   logic         c_lo_co, c_hi_co;

   int total = 0;
   int bad   = 0;
   int model = 0;
   int cmodel = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   presc_counter #(.WIDTH(W), .CHAIN(CHAIN_PARALLEL)) i_presc_counter (
      .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
      .carry_en(carry_en), .din(din), .count(count), .carry_out(carry_out));

   presc_counter #(.WIDTH(W), .CHAIN(CHAIN_SERIAL)) i_lo (
      .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .cnt_en(c_en),
      .carry_en(1'b1), .din('0), .count(c_lo), .carry_out(c_lo_co));

   presc_counter #(.WIDTH(W), .CHAIN(CHAIN_SERIAL)) i_hi (
      .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .cnt_en(c_en),
      .carry_en(c_lo_co), .din('0), .count(c_hi), .carry_out(c_hi_co));

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One clock of the main counter; model updated per requirements, then compared.
   task automatic step(bit c, bit l, bit p, bit t, int dv);
      string tag;
      @(negedge clk);
      clear_n = c; load_n = l; cnt_en = p; carry_en = t; din = W'(dv);
      @(posedge clk);
      if (!c)          begin model = 0;                 tag = "R1"; end
      else if (!l)     begin model = dv & MAXV;         tag = "R2"; end
      else if (p && t) begin model = (model + 1) & MAXV; tag = "R3"; end
      else             tag = "R4";
      #1;
      check(tag, int'(count), model);
      check((!t && model == MAXV) ? "R6" : "R5", int'(carry_out),
            (t && model == MAXV) ? 1 : 0);
   endtask

   task automatic cstep(bit c, bit e);
      @(negedge clk);
      c_clear_n = c; c_en = e;
      @(posedge clk);
      if (!c)     cmodel = 0;
      else if (e) cmodel = (cmodel + 1) & 255;
      #1;
      check("R8", int'({c_hi, c_lo}), cmodel);
   endtask

   initial begin : watchdog
      repeat (CYCLES) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL all watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int last1;
      clear_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0; din = '0;
      c_clear_n = 1'b0; c_en = 1'b0;

      // R1 reset state via clear, with load and enables also active
      step(0, 0, 1, 1, 9);
      check("R1", int'(count), 0);
      // R2 load with enables on and off
      step(1, 0, 1, 1, 5);
      step(1, 0, 0, 0, 11);
      // R3 counting
      repeat (3) step(1, 1, 1, 1, 0);
      // R4 hold with either enable low
      step(1, 1, 0, 1, 7);
      step(1, 1, 1, 0, 7);
      step(1, 1, 0, 0, 7);
      // R5 / R6 at all ones
      step(1, 0, 0, 0, MAXV);
      @(negedge clk); carry_en = 1'b1; cnt_en = 1'b0; #1;
      check("R5", int'(carry_out), 1);
      carry_en = 1'b0; cnt_en = 1'b1; #1;
      check("R6", int'(carry_out), 0);
      step(1, 1, 1, 0, 0);
      check("R6", int'(count), MAXV);
      // R7 wrap and carry drop
      step(1, 1, 1, 1, 0);
      check("R7", int'(count), 0);
      check("R7", int'(carry_out), 0);
      // R7 bit periods during free running
      last1 = int'(count[1]);
      for (int k = 1; k <= 2 * (MAXV + 1); k++) begin
         step(1, 1, 1, 1, 0);
         for (int b = 0; b < W; b++)
            check("R7", int'(count[b]), (k >> b) & 1);
      end
      // Priority: clear over load, load over count
      step(1, 0, 1, 1, 3);
      step(0, 0, 1, 1, 3);
      check("R1", int'(count), 0);
      // Random mix compared against the model every clock
      for (int k = 0; k < 400; k++) begin
         int r = $urandom_range(0, 15);
         step(r != 0, (r % 5) != 1, ($urandom_range(0, 3) != 0),
              ($urandom_range(0, 3) != 0), $urandom_range(0, MAXV));
      end

      // R8 cascade: full 8-bit cycle plus paused stretches
      cstep(0, 0);
      for (int k = 0; k < 300; k++) begin
         cstep(1, (k % 7) != 3);
         if (cmodel == 0 && k > 0) check("R8", int'(c_hi_co), 0);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule